// File: doc/BRIEF.md
# Clocked Serial Transceiver with Overrun Recovery

This block is a full-duplex synchronous serial port. Each frame moves 8 bits, most significant bit first. A serial clock comes in from an external pin. On every frame the port sends one byte on its data output and takes in one byte on its data input. A host reaches the port through a small register window with four locations:

- a control word (start, inhibit)
- a status word
- a transmit data buffer
- a receive data buffer

An interrupt request pulses at the end of every frame.

The block's main purpose is to recover cleanly from a receive overrun. An overrun happens when a frame finishes before the host has read the previous byte. When that happens the port raises an error flag and freezes both the receive buffer and the shift register. It then ignores further serial clocks until the host acts. The host reads the buffer twice: the first read returns the older byte and the second returns the byte that overran. The host then clears the error flag, which also clears receive-full, and reception resumes.

Top module: `sersh_top`

## Requirements
- R1: Each frame is 8 serial clock periods. The input is sampled on each rising serial clock edge and shifted in MSB first. The output changes on each falling edge, sending the transmit byte MSB first. The serial clock idles high.
- R2: Writing the transmit register (address 2) clears tx-empty (status bit 2). The first falling edge of a frame takes the buffer and sets tx-empty again. A frame that starts with tx-empty set sends 0xFF.
- R3: When a frame ends while receive-full (status bit 3) is clear, these happen:
  - the received byte moves to the receive register (address 3);
  - receive-full is set;
  - `irq` is high for exactly one clock.

  A read of address 3 with no error pending clears receive-full.
- R4: When a frame ends while receive-full is set, these happen:
  - receive-error (status bit 4) is set;
  - `irq` pulses once;
  - the receive register keeps the older byte.
- R5: While receive-error is set, the first read of address 3 returns the older byte. The second read returns the byte whose frame caused the error.
- R6: While receive-error is set, serial clock edges do not shift, count or raise `irq`. The held shift register contents are not disturbed.
- R7: Writing the status register (address 1) with bit 4 = 0 while receive-error is set clears both receive-error and receive-full. Reception then resumes on the next frame.
- R8: Writing control (address 0) with bit 0 = 1 sets start and busy (status bit 0). After start is written 0, busy stays 1 until one more complete frame has ended. Serial clocks are ignored while busy is 0.
- R9: Shift-end (status bit 1) is set at the end of each frame. It is cleared by writing the status register with bit 1 = 0.
- R10: Writing control with bit 1 = 1 (inhibit) stops operation at once. It clears start, busy and every status flag, sets tx-empty, and zeroes both data buffers. It also drives the serial output high.
- R11: After reset, the following hold:
  - status reads 0x04;
  - control and receive data read 0;
  - the serial output is 1;
  - `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_in | input | 1 | External serial clock, asynchronous to clk |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe; data valid on the next clock |
| host_addr | input | 2 | Register select: 0 control, 1 status, 2 transmit, 3 receive |
| host_wdata | input | FRAME_W | Write data |
| host_rdata | output | FRAME_W | Registered read data |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The bench builds the block with the defaults: an 8-bit frame and a two-stage clock synchronizer. At those values every bit of a frame can be compared one by one against the bench's own MSB-first expectation. The vector table covers the all-zeros and all-ones patterns and alternating patterns in both directions. The two-stage synchronizer puts edge detection three system clocks after a pin change. A serial half-period of four clocks therefore gives settled sample points. It also leaves room to drive a whole stalled frame after an overrun and show that it leaves no trace in the data or the interrupt count.

// File: rtl/sersh_pkg.sv
package sersh_pkg;
  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_STAT = 2'd1,
    RA_TXD  = 2'd2,
    RA_RXD  = 2'd3
  } reg_addr_e;

  localparam int unsigned CB_START   = 0;
  localparam int unsigned CB_INHIBIT = 1;

  localparam int unsigned SB_BUSY   = 0;
  localparam int unsigned SB_SHEND  = 1;
  localparam int unsigned SB_TXEMP  = 2;
  localparam int unsigned SB_RXFULL = 3;
  localparam int unsigned SB_RXERR  = 4;
endpackage

// File: rtl/sersh_sync.sv
module sersh_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-1:0], pin};
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];
  assign fall = ~chain[STAGES-1] & chain[STAGES];

  p_edge_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rise || fall) |=> !(rise || fall));
endmodule

// File: rtl/sersh_shifter.sv
module sersh_shifter #(
  parameter int unsigned FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               run,
  input  logic               rise,
  input  logic               fall,
  input  logic               sdi,
  input  logic [FRAME_W-1:0] tx_word,
  output logic               sdo,
  output logic               frame_done,
  output logic               tx_taken,
  output logic [FRAME_W-1:0] rx_word,
  output logic [FRAME_W-1:0] sh_q
);
  localparam int unsigned CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] txsh;

  function automatic logic [FRAME_W-1:0] shift_in(input logic [FRAME_W-1:0] v, input logic b);
    return {v[FRAME_W-2:0], b};
  endfunction

  function automatic logic [CNT_W-1:0] next_cnt(input logic [CNT_W-1:0] c);
    return (c == LAST) ? '0 : c + 1'b1;
  endfunction

  assign frame_done = run & rise & (cnt == LAST);
  assign tx_taken   = run & fall & (cnt == '0);
  assign rx_word    = shift_in(sh_q, sdi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sh_q <= '0;
      txsh <= '0;
      sdo  <= 1'b1;
    end else if (clear) begin
      cnt  <= '0;
      sh_q <= '0;
      txsh <= '0;
      sdo  <= 1'b1;
    end else if (run) begin
      if (fall) begin
        if (cnt == '0) begin
          sdo  <= tx_word[FRAME_W-1];
          txsh <= tx_word << 1;
        end else begin
          sdo  <= txsh[FRAME_W-1];
          txsh <= txsh << 1;
        end
      end
      if (rise) begin
        sh_q <= rx_word;
        cnt  <= next_cnt(cnt);
      end
    end
  end

  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clear) |=> ($stable(sh_q) && $stable(cnt) && $stable(sdo)));
  p_count_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !clear) |=> (cnt == '0));
endmodule

// File: rtl/sersh_regs.sv
module sersh_regs
  import sersh_pkg::*;
#(
  parameter int unsigned FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [1:0]         host_addr,
  input  logic [FRAME_W-1:0] host_wdata,
  output logic [FRAME_W-1:0] host_rdata,
  input  logic               frame_done,
  input  logic               tx_taken,
  input  logic [FRAME_W-1:0] rx_word,
  input  logic [FRAME_W-1:0] sh_q,
  output logic               clear,
  output logic               run,
  output logic [FRAME_W-1:0] tx_word,
  output logic               irq
);
  logic               start_q, busy_q, shend_q, txfull_q, rxfull_q, rxerr_q, phase_q;
  logic [FRAME_W-1:0] txbuf_q, rxbuf_q;
  logic               wr_ctrl, wr_stat, wr_txd, rd_rxd;

  function automatic logic [FRAME_W-1:0] pack_status(
    input logic busy, input logic shend, input logic txemp,
    input logic rxfull, input logic rxerr);
    logic [FRAME_W-1:0] s;
    s            = '0;
    s[SB_BUSY]   = busy;
    s[SB_SHEND]  = shend;
    s[SB_TXEMP]  = txemp;
    s[SB_RXFULL] = rxfull;
    s[SB_RXERR]  = rxerr;
    return s;
  endfunction

  assign wr_ctrl = host_wr & (host_addr == RA_CTRL);
  assign wr_stat = host_wr & (host_addr == RA_STAT);
  assign wr_txd  = host_wr & (host_addr == RA_TXD);
  assign rd_rxd  = host_rd & (host_addr == RA_RXD);
  assign clear   = wr_ctrl & host_wdata[CB_INHIBIT];
  assign run     = busy_q & ~rxerr_q;
  assign tx_word = txfull_q ? txbuf_q : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0; busy_q <= 1'b0; shend_q <= 1'b0; txfull_q <= 1'b0;
      rxfull_q <= 1'b0; rxerr_q <= 1'b0; phase_q <= 1'b0;
      txbuf_q <= '0; rxbuf_q <= '0; irq <= 1'b0;
    end else if (clear) begin
      start_q <= 1'b0; busy_q <= 1'b0; shend_q <= 1'b0; txfull_q <= 1'b0;
      rxfull_q <= 1'b0; rxerr_q <= 1'b0; phase_q <= 1'b0;
      txbuf_q <= '0; rxbuf_q <= '0; irq <= 1'b0;
    end else begin
      irq <= frame_done;
      if (rd_rxd) begin
        if (rxerr_q) phase_q <= 1'b1;
        else         rxfull_q <= 1'b0;
      end
      if (wr_stat) begin
        if (!host_wdata[SB_SHEND]) shend_q <= 1'b0;
        if (!host_wdata[SB_RXERR] && rxerr_q) begin
          rxerr_q  <= 1'b0;
          rxfull_q <= 1'b0;
          phase_q  <= 1'b0;
        end
      end
      if (frame_done) begin
        shend_q <= 1'b1;
        if (!start_q) busy_q <= 1'b0;
        if (rxfull_q) rxerr_q <= 1'b1;
        else begin
          rxbuf_q  <= rx_word;
          rxfull_q <= 1'b1;
        end
      end
      if (wr_ctrl) begin
        start_q <= host_wdata[CB_START];
        if (host_wdata[CB_START]) busy_q <= 1'b1;
      end
      if (wr_txd) begin
        txbuf_q  <= host_wdata;
        txfull_q <= 1'b1;
      end else if (tx_taken) begin
        txfull_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) host_rdata <= '0;
    else if (host_rd) begin
      unique case (reg_addr_e'(host_addr))
        RA_CTRL: host_rdata <= FRAME_W'(start_q);
        RA_STAT: host_rdata <= pack_status(busy_q, shend_q, ~txfull_q, rxfull_q, rxerr_q);
        RA_TXD:  host_rdata <= txbuf_q;
        RA_RXD:  host_rdata <= (rxerr_q && phase_q) ? sh_q : rxbuf_q;
        default: host_rdata <= '0;
      endcase
    end
  end

  p_err_has_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rxerr_q |-> rxfull_q);
  p_buf_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rxerr_q && !clear) |=> $stable(rxbuf_q));
  p_irq_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  p_inhibit_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!busy_q && !start_q && !rxfull_q && !rxerr_q && !txfull_q && !shend_q));
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !frame_done && !clear) |=> busy_q);
  p_err_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rxerr_q && wr_stat && !host_wdata[SB_RXERR] && !clear) |=> (!rxerr_q && !rxfull_q));
endmodule

// File: rtl/sersh_top.sv
module sersh_top #(
  parameter int unsigned FRAME_W     = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sck_in,
  input  logic               sdi,
  output logic               sdo,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [1:0]         host_addr,
  input  logic [FRAME_W-1:0] host_wdata,
  output logic [FRAME_W-1:0] host_rdata,
  output logic               irq
);
  logic               sck_rise, sck_fall, clear, run, frame_done, tx_taken;
  logic [FRAME_W-1:0] tx_word, rx_word, sh_q;

  sersh_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(sck_in), .rise(sck_rise), .fall(sck_fall)
  );

  sersh_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clear(clear), .run(run),
    .rise(sck_rise), .fall(sck_fall), .sdi(sdi), .tx_word(tx_word),
    .sdo(sdo), .frame_done(frame_done), .tx_taken(tx_taken),
    .rx_word(rx_word), .sh_q(sh_q)
  );

  sersh_regs #(.FRAME_W(FRAME_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .frame_done(frame_done), .tx_taken(tx_taken), .rx_word(rx_word),
    .sh_q(sh_q), .clear(clear), .run(run), .tx_word(tx_word), .irq(irq)
  );
endmodule

// File: tb/sim_sersh_top.sv
`timescale 1ns/1ps
module sim_sersh_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sck_in = 1'b1;
  logic       sdi = 1'b0;
  logic       sdo;
  logic       host_wr = 1'b0;
  logic       host_rd = 1'b0;
  logic [1:0] host_addr = 2'd0;
  logic [7:0] host_wdata = 8'd0;
  logic [7:0] host_rdata;
  logic       irq;

  int checks = 0;
  int fails = 0;
  int irq_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sersh_top u0 (
    .clk(clk), .rst_n(rst_n), .sck_in(sck_in), .sdi(sdi), .sdo(sdo),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq)
  );

  always @(negedge clk) if (irq) irq_cnt++;

  // {transmit byte, byte driven on sdi}
  localparam logic [15:0] VEC [5] = '{
    16'hA5_3C, 16'h00_FF, 16'hFF_00, 16'h81_7E, 16'h5A_C3
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); host_rd = 1'b1; host_addr = a;
    @(negedge clk); host_rd = 1'b0; d = host_rdata;
  endtask

  task automatic frame(input logic [7:0] din, output logic [7:0] dout);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); sck_in = 1'b0; sdi = din[i];
      repeat (4) @(negedge clk);
      dout[i] = sdo;
      sck_in = 1'b1;
      repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, so;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R11 reset state
    rd(2'd1, r); check("R11 status", r, 8'h04);
    rd(2'd0, r); check("R11 control", r, 8'h00);
    rd(2'd3, r); check("R11 rx data", r, 8'h00);
    check("R11 sdo", sdo, 1); check("R11 irq", irq_cnt, 0);

    // R8 start sets busy
    wr(2'd0, 8'h01);
    rd(2'd1, r); check("R8 busy set", r, 8'h05);

    foreach (VEC[k]) begin
      base = irq_cnt;
      wr(2'd2, VEC[k][15:8]);
      rd(2'd1, r); check("R2 tx_empty cleared", r, 8'h01);
      frame(VEC[k][7:0], so);
      check("R1 sdo byte", so, VEC[k][15:8]);
      check("R3 one irq", irq_cnt, base + 1);
      rd(2'd1, r); check("R3 R9 status after frame", r, 8'h0F);
      rd(2'd3, r); check("R3 R1 rx byte", r, VEC[k][7:0]);
      rd(2'd1, r); check("R3 rx_full cleared", r, 8'h07);
      wr(2'd1, 8'h00);
      rd(2'd1, r); check("R9 shift-end cleared", r, 8'h05);
    end

    // R2 empty transmit buffer sends all ones; leaves rx_full set
    frame(8'h96, so); check("R2 idle fill", so, 8'hFF);

    // R4 overrun
    base = irq_cnt;
    frame(8'h4B, so);
    check("R4 irq on error", irq_cnt, base + 1);
    rd(2'd1, r); check("R4 error status", r, 8'h1F);

    // R6 stalled frame ignored
    frame(8'hE1, so);
    check("R6 no irq while stalled", irq_cnt, base + 1);

    // R5 double read
    rd(2'd3, r); check("R5 first read older byte", r, 8'h96);
    rd(2'd3, r); check("R5 R6 second read shift byte", r, 8'h4B);

    // R7 clear error
    wr(2'd1, 8'h02);
    rd(2'd1, r); check("R7 error and full cleared", r, 8'h07);
    frame(8'h2D, so);
    rd(2'd3, r); check("R7 reception resumed", r, 8'h2D);

    // R8 busy persists for one frame after start cleared
    wr(2'd0, 8'h00);
    rd(2'd1, r); check("R8 busy kept", r, 8'h07);
    frame(8'hD2, so);
    rd(2'd1, r); check("R8 busy cleared after frame", r, 8'h0E);
    rd(2'd3, r); check("R8 final frame data", r, 8'hD2);
    base = irq_cnt;
    frame(8'h11, so);
    check("R8 idle ignores clock", irq_cnt, base);

    // R10 inhibit
    wr(2'd0, 8'h01);
    wr(2'd2, 8'h33);
    wr(2'd0, 8'h02);
    rd(2'd1, r); check("R10 status reset", r, 8'h04);
    rd(2'd3, r); check("R10 rx buffer zeroed", r, 8'h00);
    rd(2'd2, r); check("R10 tx buffer zeroed", r, 8'h00);
    rd(2'd0, r); check("R10 start cleared", r, 8'h00);
    check("R10 sdo high", sdo, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule